// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer after a miss. It takes a 20-bit virtual page number and walks a two-level page table held in physical memory, which it reads directly without translation. The upper ten bits of the page number select a word in the first-level table. The table's base comes from a root input, which the operating system reloads whenever the running process changes. If the word read there is marked present, its page number names the second-level table. The lower ten bits of the page number then select a word in that table. If that word is also present, the block returns its physical page number and its permission bits as a refill. If either word is marked absent, the block stops at once and reports a fault that carries the level at which it stopped.

Each table entry is 32 bits wide. Entry addresses are byte addresses, so an index is multiplied by four before it is added to a table base. The walker keeps only one walk in flight at a time. It accepts a new miss only while idle. It issues one memory read at a time and waits for the matching response, however many cycles that takes. Each walk ends with a one-cycle result pulse.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and on the first cycle after it, `miss_ready` is 1 and `mem_req_valid`, `fill_valid` and `fault_valid` are all 0.
- R2: A miss is taken only on a cycle where `miss_valid` and `miss_ready` are both 1. From the cycle after that until the result pulse, `miss_ready` is 0 and `miss_valid` and `miss_vpn` have no effect.
- R3: The first memory read of a walk goes to `root + 4*vpn[19:10]`. Here `vpn[19:10]` are bits 31:22 of the virtual address, and `root` is the value `root_base` had in the cycle the miss was taken.
- R4: The second read goes to `(E1[31:12] << 12) + 4*vpn[9:0]`, where E1 is the first-level entry.
- R5: `mem_req_valid` stays high with a stable address until `mem_req_ready` is 1. After that handshake, no new read is issued until a `mem_resp_valid` cycle has been taken.
- R6: If bit 0 (present) of the first-level entry is 0, no second read is made. The next cycle shows `fault_valid` = 1 with `fault_level` = 0.
- R7: If bit 0 of the second-level entry is 0, the next cycle shows `fault_valid` = 1 with `fault_level` = 1.
- R8: If the second-level entry E2 is present, the next cycle shows `fill_valid` = 1 with `fill_ppn` = E2[31:12], `fill_read` = E2[1], `fill_write` = E2[2], `fill_dirty` = E2[3], and `rsp_vpn` equal to the page number that was taken.
- R9: `fill_valid` and `fault_valid` are never high together. Each lasts exactly one cycle, and `miss_ready` returns to 1 on the following cycle.
- R10: A change of `root_base` after a miss has been taken has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical byte address of the first-level table |
| miss_valid | input | 1 | Miss request present |
| miss_vpn | input | 20 | Virtual page number of the miss |
| miss_ready | output | 1 | Walker idle, miss can be taken |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Physical byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Read data returned |
| mem_resp_data | input | 32 | Entry word read from memory |
| fill_valid | output | 1 | One-cycle pulse: walk succeeded |
| fill_ppn | output | 20 | Physical page number for the refill |
| fill_read | output | 1 | Page readable |
| fill_write | output | 1 | Page writable |
| fill_dirty | output | 1 | Page dirty |
| fault_valid | output | 1 | One-cycle pulse: walk found an absent entry |
| fault_level | output | 1 | 0 when the walk stopped at the first level, 1 at the second |
| rsp_vpn | output | 20 | Page number of the walk being reported |

## Verification
A wrong walk state shows on the ports within the same cycle. A wrong state either raises or drops `miss_ready` or `mem_req_valid` against what the walk sequence expects, or produces a result pulse at the wrong time. A stale or wrongly captured root, page number or table base shows on the next memory request address, at the latest one handshake later. A wrong capture of the leaf entry shows in the fill fields on the single pulse cycle. A per-clock reference model with random memory latency and randomly absent entries at both levels compares all of these outputs on every cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    W_IDLE,
    W_L1_REQ,
    W_L1_WAIT,
    W_L2_REQ,
    W_L2_WAIT,
    W_DONE,
    W_FAULT
  } walk_state_e;

  // entry flag positions
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_D = 3;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_fire,
  input  logic        mem_req_ready,
  input  logic        mem_resp_valid,
  input  logic        entry_present,
  output walk_state_e state,
  output logic        fault_lvl
);

  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      W_IDLE:    if (miss_fire) nxt = W_L1_REQ;
      W_L1_REQ:  if (mem_req_ready) nxt = W_L1_WAIT;
      W_L1_WAIT: if (mem_resp_valid) nxt = entry_present ? W_L2_REQ : W_FAULT;
      W_L2_REQ:  if (mem_req_ready) nxt = W_L2_WAIT;
      W_L2_WAIT: if (mem_resp_valid) nxt = entry_present ? W_DONE : W_FAULT;
      W_DONE:    nxt = W_IDLE;
      W_FAULT:   nxt = W_IDLE;
      default:   nxt = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= W_IDLE;
      fault_lvl <= 1'b0;
    end else begin
      state <= nxt;
      if (mem_resp_valid && state == W_L1_WAIT) fault_lvl <= 1'b0;
      else if (mem_resp_valid && state == W_L2_WAIT) fault_lvl <= 1'b1;
    end
  end

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int OFF_W     = 12,
  parameter int PTE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  walk_state_e             state,
  input  logic                    miss_fire,
  input  logic [2*IDX_W-1:0]      miss_vpn,
  input  logic [PA_W-1:0]         root_base,
  input  logic                    l1_take,
  input  logic [PA_W-OFF_W-1:0]   resp_ppn,
  output logic [PA_W-1:0]         req_addr,
  output logic [2*IDX_W-1:0]      vpn_q
);

  localparam int VPN_W = 2 * IDX_W;
  localparam int SH    = $clog2(PTE_BYTES);

  logic [PA_W-1:0] root_q;
  logic [PA_W-1:0] l2_base_q;

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return base + (PA_W'(idx) << SH);
  endfunction

  function automatic logic [PA_W-1:0] page_base(input logic [PA_W-OFF_W-1:0] ppn);
    return {ppn, {OFF_W{1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vpn_q     <= '0;
      root_q    <= '0;
      l2_base_q <= '0;
    end else begin
      if (miss_fire) begin
        vpn_q  <= miss_vpn;
        root_q <= root_base;
      end
      if (l1_take) l2_base_q <= page_base(resp_ppn);
    end
  end

  always_comb begin
    if (state == W_L2_REQ) req_addr = entry_addr(l2_base_q, vpn_q[IDX_W-1:0]);
    else                   req_addr = entry_addr(root_q, vpn_q[VPN_W-1:IDX_W]);
  end

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  walk_state_e           state,
  input  logic                  resp_valid,
  input  logic [PA_W-1:0]       resp_data,
  output logic                  present,
  output logic                  ev_l1_ok,
  output logic                  ev_l1_fault,
  output logic                  ev_l2_ok,
  output logic                  ev_l2_fault,
  output logic [PA_W-OFF_W-1:0] leaf_ppn,
  output logic                  leaf_r,
  output logic                  leaf_w,
  output logic                  leaf_d
);

  logic l1_seen;
  logic l2_seen;
  logic unused_rsv;

  assign unused_rsv = ^resp_data[OFF_W-1:PTE_D+1];

  assign present     = resp_data[PTE_V];
  assign l1_seen     = resp_valid && state == W_L1_WAIT;
  assign l2_seen     = resp_valid && state == W_L2_WAIT;
  assign ev_l1_ok    = l1_seen && present;
  assign ev_l1_fault = l1_seen && !present;
  assign ev_l2_ok    = l2_seen && present;
  assign ev_l2_fault = l2_seen && !present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leaf_ppn <= '0;
      leaf_r   <= 1'b0;
      leaf_w   <= 1'b0;
      leaf_d   <= 1'b0;
    end else if (ev_l2_ok) begin
      leaf_ppn <= resp_data[PA_W-1:OFF_W];
      leaf_r   <= resp_data[PTE_R];
      leaf_w   <= resp_data[PTE_W];
      leaf_d   <= resp_data[PTE_D];
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W      = 32,
  parameter int IDX_W     = 10,
  parameter int OFF_W     = 12,
  parameter int PTE_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PA_W-1:0]         root_base,
  input  logic                    miss_valid,
  input  logic [2*IDX_W-1:0]      miss_vpn,
  output logic                    miss_ready,
  output logic                    mem_req_valid,
  output logic [PA_W-1:0]         mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_resp_valid,
  input  logic [PA_W-1:0]         mem_resp_data,
  output logic                    fill_valid,
  output logic [PA_W-OFF_W-1:0]   fill_ppn,
  output logic                    fill_read,
  output logic                    fill_write,
  output logic                    fill_dirty,
  output logic                    fault_valid,
  output logic                    fault_level,
  output logic [2*IDX_W-1:0]      rsp_vpn
);

  localparam int VPN_W = 2 * IDX_W;
  localparam int PPN_W = PA_W - OFF_W;

  walk_state_e      state;
  logic             miss_fire;
  logic             present;
  logic             ev_l1_ok;
  logic             ev_l1_fault;
  logic             ev_l2_ok;
  logic             ev_l2_fault;
  logic             fault_lvl;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] leaf_ppn;

  assign miss_ready    = state == W_IDLE;
  assign miss_fire     = miss_valid && miss_ready;
  assign mem_req_valid = state == W_L1_REQ || state == W_L2_REQ;
  assign fill_valid    = state == W_DONE;
  assign fault_valid   = state == W_FAULT;
  assign fault_level   = fault_lvl;
  assign rsp_vpn       = vpn_q;
  assign fill_ppn      = leaf_ppn;

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_fire     (miss_fire),
    .mem_req_ready (mem_req_ready),
    .mem_resp_valid(mem_resp_valid),
    .entry_present (present),
    .state         (state),
    .fault_lvl     (fault_lvl)
  );

  ptw_addr_gen #(
    .PA_W     (PA_W),
    .IDX_W    (IDX_W),
    .OFF_W    (OFF_W),
    .PTE_BYTES(PTE_BYTES)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .miss_fire(miss_fire),
    .miss_vpn (miss_vpn),
    .root_base(root_base),
    .l1_take  (ev_l1_ok),
    .resp_ppn (mem_resp_data[PA_W-1:OFF_W]),
    .req_addr (mem_req_addr),
    .vpn_q    (vpn_q)
  );

  ptw_pte_eval #(
    .PA_W (PA_W),
    .OFF_W(OFF_W)
  ) u_pte (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .resp_valid (mem_resp_valid),
    .resp_data  (mem_resp_data),
    .present    (present),
    .ev_l1_ok   (ev_l1_ok),
    .ev_l1_fault(ev_l1_fault),
    .ev_l2_ok   (ev_l2_ok),
    .ev_l2_fault(ev_l2_fault),
    .leaf_ppn   (leaf_ppn),
    .leaf_r     (fill_read),
    .leaf_w     (fill_write),
    .leaf_d     (fill_dirty)
  );

endmodule

// File: rtl/ptw_checks.sv
module ptw_checks #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            miss_valid,
  input logic            miss_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            fill_valid,
  input logic            fault_valid,
  input logic            fault_level,
  input logic            ev_l1_fault,
  input logic            ev_l2_fault,
  input logic            ev_l2_ok
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> miss_ready && !mem_req_valid && !fill_valid && !fault_valid);

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !miss_ready);

  p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !mem_req_valid);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  p_l1_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l1_fault |=> fault_valid && !fault_level && !mem_req_valid);

  p_l2_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l2_fault |=> fault_valid && fault_level);

  p_leaf_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_l2_ok |=> fill_valid && !fault_valid);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fault_valid));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid || fault_valid |=> miss_ready && !fill_valid && !fault_valid);

endmodule

bind ptw_walker ptw_checks #(.PA_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .fill_valid   (fill_valid),
  .fault_valid  (fault_valid),
  .fault_level  (fault_level),
  .ev_l1_fault  (ev_l1_fault),
  .ev_l2_fault  (ev_l2_fault),
  .ev_l2_ok     (ev_l2_ok)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 60000;
  localparam int WALKS      = 400;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_base;
  logic        miss_valid;
  logic [19:0] miss_vpn;
  logic        miss_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready;
  logic        mem_resp_valid;
  logic [31:0] mem_resp_data;
  logic        fill_valid;
  logic [19:0] fill_ppn;
  logic        fill_read, fill_write, fill_dirty;
  logic        fault_valid, fault_level;
  logic [19:0] rsp_vpn;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .miss_valid(miss_valid), .miss_vpn(miss_vpn), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data), .fill_valid(fill_valid), .fill_ppn(fill_ppn),
    .fill_read(fill_read), .fill_write(fill_write), .fill_dirty(fill_dirty),
    .fault_valid(fault_valid), .fault_level(fault_level), .rsp_vpn(rsp_vpn)
  );

  logic [31:0] mem [0:4095];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference walk state
  int          phase;      // 0 idle,1 L1 read,2 L1 wait,3 L2 read,4 L2 wait,5 fill,6 fault
  logic [19:0] m_vpn;
  logic [31:0] m_root, m_l1, m_leaf;
  logic        m_lvl;
  bit          pending;
  logic [31:0] paddr;
  int          lat;
  int          walks, n_f1, n_f2, n_ok, cyc;

  initial begin
    for (int i = 0; i < 4096; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i < 1024 || i >= 3072)   // pages 0 and 3: first-level tables
        w = {20'(1 + $urandom % 2), w[11:1], 1'b0};
      w[0] = ($urandom % 4) != 0;
      mem[i] = w;
    end
    rst_n = 1'b0; root_base = 32'h0; miss_valid = 1'b0; miss_vpn = '0;
    mem_req_ready = 1'b0; mem_resp_valid = 1'b0; mem_resp_data = '0;
    phase = 0; pending = 0; lat = 0; walks = 0; n_f1 = 0; n_f2 = 0; n_ok = 0; cyc = 0;
    m_vpn = '0; m_root = '0; m_l1 = '0; m_leaf = '0; m_lvl = 0; paddr = '0;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    check(miss_ready && !mem_req_valid && !fill_valid && !fault_valid, "R1",
          {miss_ready, mem_req_valid, fill_valid, fault_valid}, 32'h8);
    rst_n = 1'b1;
    while (walks < WALKS && cyc < MAX_CYC) begin
      @(negedge clk);
      cyc++;
      // compare against the reference
      check(miss_ready == (phase == 0), "R2", miss_ready, phase == 0);
      check(mem_req_valid == (phase == 1 || phase == 3), "R5", mem_req_valid,
            phase == 1 || phase == 3);
      if (phase == 1)
        check(mem_req_addr == m_root + {m_vpn[19:10], 2'b00},
              (root_base != m_root) ? "R10" : "R3", mem_req_addr,
              m_root + {m_vpn[19:10], 2'b00});
      if (phase == 3)
        check(mem_req_addr == {m_l1[31:12], 12'h0} + {m_vpn[9:0], 2'b00}, "R4",
              mem_req_addr, {m_l1[31:12], 12'h0} + {m_vpn[9:0], 2'b00});
      check(fill_valid == (phase == 5), "R9", fill_valid, phase == 5);
      check(fault_valid == (phase == 6), "R9", fault_valid, phase == 6);
      if (phase == 5) begin
        check(fill_ppn == m_leaf[31:12], "R8", fill_ppn, m_leaf[31:12]);
        check({fill_dirty, fill_write, fill_read} == m_leaf[3:1], "R8",
              {fill_dirty, fill_write, fill_read}, m_leaf[3:1]);
        check(rsp_vpn == m_vpn, "R8", rsp_vpn, m_vpn);
      end
      if (phase == 6)
        check(fault_level == m_lvl, m_lvl ? "R7" : "R6", fault_level, m_lvl);
      // memory responder
      if (mem_resp_valid) begin
        mem_resp_valid = 1'b0;
        mem_resp_data  = $urandom;
      end else if (pending) begin
        if (lat > 0) lat--;
        else begin
          mem_resp_valid = 1'b1;
          mem_resp_data  = mem[paddr[13:2]];
          pending = 0;
        end
      end
      if (!(mem_req_valid && mem_req_ready)) mem_req_ready = ($urandom % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        pending = 1;
        paddr   = mem_req_addr;
        lat     = $urandom % 4;
      end
      // miss source and root changes (also while busy: must be ignored)
      miss_valid = ($urandom % 3) == 0;
      miss_vpn   = 20'($urandom);
      if ($urandom % 6 == 0) root_base = ($urandom % 2) ? 32'h3000 : 32'h0;
      // advance the reference on the values the next edge will see
      case (phase)
        0: if (miss_valid) begin m_vpn = miss_vpn; m_root = root_base; phase = 1; end
        1: if (mem_req_ready) phase = 2;
        2: if (mem_resp_valid) begin
             if (!mem_resp_data[0]) begin m_lvl = 0; phase = 6; n_f1++; end
             else begin m_l1 = mem_resp_data; phase = 3; end
           end
        3: if (mem_req_ready) phase = 4;
        4: if (mem_resp_valid) begin
             if (!mem_resp_data[0]) begin m_lvl = 1; phase = 6; n_f2++; end
             else begin m_leaf = mem_resp_data; phase = 5; n_ok++; end
           end
        default: begin phase = 0; walks++; end
      endcase
    end
    if (cyc >= MAX_CYC) check(0, "watchdog", cyc, MAX_CYC);
    check(n_f1 > 0, "R6", n_f1, 1);
    check(n_f2 > 0, "R7", n_f2, 1);
    check(n_ok > 0, "R8", n_ok, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule